// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a twelve-bit mode word into the settings that govern column bursts in a synchronous memory controller: burst length, address ordering, read latency and write behaviour. After the settings are latched, every accepted read or write command loads a nine-bit starting column. The block then puts out one column address per clock for as many beats as the burst calls for, and it marks the final beat.

The addresses follow one of two orderings. In sequential order the column counts upward inside its burst-aligned block and wraps within it. In interleaved order the low bits of the start are XORed with the beat number. A full-page burst runs through all 512 columns, wraps from the top back to zero and continues until a terminate request or a new command ends it. A newly accepted command replaces a running burst on any clock. An optional mode limits every write to one beat while reads keep their full length.

The controller that drives the block sets `mode_load` to program the settings and `cmd_valid` to start a burst. It uses `col_addr` while `col_valid` is high.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid` and `mode_err` are 0, the burst length is 1 (`cfg_len_log`=0), ordering is sequential, read latency is 2 and writes use the programmed length.
- R2: When `mode_load` is high and the word holds no reserved code, the settings are taken on that clock edge. Bits [2:0] give the length: 000, 001, 010 and 011 give 1, 2, 4 and 8 beats (`cfg_len_log` 0..3), and 111 gives full page (`cfg_len_log`=9). Bit 3 selects interleaved order (1) or sequential order (0). Bits [6:4] equal to 010 or 011 give a read latency of 2 or 3. Bit 9 set to 1 selects single-beat writes. Bits 7, 8, 10 and 11 are ignored.
- R3: A loaded word whose length code is 100, 101 or 110, whose length code is 111 with bit 3 set, or whose latency code is neither 010 nor 011 sets `mode_err` on the next cycle and leaves every setting unchanged. A valid load clears `mode_err`.
- R4: A command accepted on a clock edge (`cmd_valid` high) makes `col_valid` high in the next cycle with `col_addr` equal to `cmd_col`. Each further clock presents the next beat.
- R5: In sequential order beat k has its low log2(L) bits equal to (start + k) mod L and its upper bits equal to those of the start, where L is the burst length.
- R6: In interleaved order beat k is the start XOR k.
- R7: `col_last` is high exactly on beat L-1. In the cycle after it, `col_valid` is 0 unless a new command was accepted.
- R8: A full-page burst addresses (start + k) mod 512, never raises `col_last` and continues until it is terminated or replaced.
- R9: When `term` is high during an active burst and no command is given, `col_valid` is 0 in the next cycle. When no burst is active, `term` has no effect.
- R10: A command accepted during a burst, even in the same cycle as `term`, restarts the output at its own start column with beat 0 in the next cycle.
- R11: With bit 9 set, a write burst is one beat long and has `col_last` high on that beat, while a read keeps the programmed length. With bit 9 clear, writes use the programmed length.
- R12: A burst keeps the length and ordering that were in force when it was accepted. A command given in the same cycle as `mode_load` uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_load | input | 1 | Latch `mode_word` on this edge |
| mode_word | input | 12 | Mode word to decode |
| cmd_valid | input | 1 | Read or write command accepted |
| cmd_is_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | 9 | Starting column of the command |
| term | input | 1 | Terminate the running burst |
| col_valid | output | 1 | `col_addr` holds a burst beat |
| col_addr | output | 9 | Column for the current beat |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Last loaded word held a reserved code |
| cfg_len_log | output | 4 | log2 of the burst length (9 means full page) |
| cfg_interleave | output | 1 | Interleaved ordering selected |
| cfg_rd_lat | output | 2 | Read latency in clocks |
| cfg_single_wr | output | 1 | Single-beat write mode selected |

## Verification
The assertions check the following on every cycle: a command makes the start column appear on the next cycle; the cycle after a final beat or a terminate is idle; `col_last` never appears without `col_valid`; a rejected mode word leaves the settings unchanged; and the latency output always holds a legal value. The beat-by-beat address orders (the sequential wrap inside the aligned block, the XOR pattern, the full-page roll from 511 to 0) are shown only by the bench's scenarios. The same holds for single-beat writes, replacement in mid-burst and the rule that settings are captured when a command is accepted. The bench sets up each of these with chosen mode words and start columns and compares every beat against its own address model.

// File: rtl/bcg_pkg.sv
// Package for the burst column generator.
// Holds the field positions of the mode word, the decoded settings type and
// the decoding function that the mode register uses.
package bcg_pkg;

    localparam int MODE_W  = 12;
    localparam int LEN_LSB = 0;
    localparam int ORD_BIT = 3;
    localparam int LAT_LSB = 4;
    localparam int WRM_BIT = 9;

    typedef struct packed {
        logic [3:0] len_log;    // log2 of beats per burst
        logic       interleave; // 1 = XOR ordering
        logic [1:0] rd_lat;     // read latency in clocks
        logic       single_wr;  // writes are one beat
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic bad;
    } mode_dec_t;

    localparam cfg_t CFG_RESET = '{len_log: 4'd0, interleave: 1'b0,
                                   rd_lat: 2'd2, single_wr: 1'b0};

    // Decode a mode word; full_log is the len_log value for full page.
    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] w,
                                              input logic [3:0] full_log);
        mode_dec_t r;
        r = '0;
        r.cfg.interleave = w[ORD_BIT];
        r.cfg.single_wr  = w[WRM_BIT];
        case (w[LEN_LSB +: 3])
            3'b000:  r.cfg.len_log = 4'd0;
            3'b001:  r.cfg.len_log = 4'd1;
            3'b010:  r.cfg.len_log = 4'd2;
            3'b011:  r.cfg.len_log = 4'd3;
            3'b111: begin
                r.cfg.len_log = full_log;
                if (w[ORD_BIT]) r.bad = 1'b1;
            end
            default: r.bad = 1'b1;
        endcase
        case (w[LAT_LSB +: 3])
            3'b010:  r.cfg.rd_lat = 2'd2;
            3'b011:  r.cfg.rd_lat = 2'd3;
            default: r.bad = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcg_mode_reg.sv
// Mode register.
// Decodes the mode word when a load arrives. The settings are taken only if
// the word holds no reserved code; otherwise the error flag is set and the
// old settings stay. Assumes the full-page log fits in four bits.
module bcg_mode_reg
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output cfg_t              cfg,
    output logic              err
);

    localparam logic [3:0] FULL_LOG = 4'(COL_W);

    mode_dec_t dec;

    // Decode the incoming word every cycle.
    always_comb begin
        dec = decode_mode(word, FULL_LOG);
    end

    // Latch valid settings or flag a reserved code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (load) begin
            if (dec.bad) begin
                err <= 1'b1;
            end else begin
                cfg <= dec.cfg;
                err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bcg_burst_ctl.sv
// Burst controller.
// Captures the start column, length and ordering when a command is accepted,
// then counts beats. Ends the burst on the final beat or on terminate; a new
// command takes priority over both. Full-page bursts have no final beat.
module bcg_burst_ctl
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             term,
    input  cfg_t             cfg,
    output logic             active,
    output logic [COL_W-1:0] start,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] mask,
    output logic             ilv,
    output logic             last
);

    localparam logic [3:0] FULL_LOG = 4'(COL_W);

    logic [3:0] len_log;
    logic [3:0] eff_log;
    logic       full;

    // Length to capture: single-beat writes override the programmed length.
    always_comb begin
        eff_log = (cfg.single_wr && cmd_write) ? 4'd0 : cfg.len_log;
    end

    // One mask bit for each column bit that the burst walks through.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask[i] = (len_log > 4'(i));
    end

    assign full = (len_log == FULL_LOG);
    assign last = active && !full && (beat == mask);

    // Start, advance and end bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            start   <= '0;
            beat    <= '0;
            len_log <= 4'd0;
            ilv     <= 1'b0;
        end else if (cmd_valid) begin
            active  <= 1'b1;
            start   <= cmd_col;
            beat    <= '0;
            len_log <= eff_log;
            ilv     <= cfg.interleave;
        end else if (active) begin
            if (term || last) begin
                active <= 1'b0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcg_addr_gen.sv
// Address generator.
// Forms the column for the current beat. Column bits outside the mask come
// from the start; bits inside it take either the sum of start and beat or
// their XOR. Assumes beat never exceeds the mask (the controller ensures it).
module bcg_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] sum;

    assign sum = start + beat;

    // Choose each column bit by mask and ordering.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign addr[i] = !mask[i] ? start[i]
                       : (ilv ? (start[i] ^ beat[i]) : sum[i]);
    end

endmodule

// File: rtl/burst_col_gen.sv
// Burst column address generator, top level.
// Joins the mode register, the burst controller and the address generator.
// Assumes the commands it receives are already legal: the block accepts
// whatever arrives on cmd_valid.
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_valid,
    input  logic              cmd_is_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              term,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_last,
    output logic              mode_err,
    output logic [3:0]        cfg_len_log,
    output logic              cfg_interleave,
    output logic [1:0]        cfg_rd_lat,
    output logic              cfg_single_wr
);

    cfg_t             cfg;
    logic [COL_W-1:0] start;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask;
    logic             ilv;

    bcg_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .word  (mode_word),
        .cfg   (cfg),
        .err   (mode_err)
    );

    bcg_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_is_write),
        .cmd_col   (cmd_col),
        .term      (term),
        .cfg       (cfg),
        .active    (col_valid),
        .start     (start),
        .beat      (beat),
        .mask      (mask),
        .ilv       (ilv),
        .last      (col_last)
    );

    bcg_addr_gen #(.COL_W(COL_W)) u_addr (
        .start (start),
        .beat  (beat),
        .mask  (mask),
        .ilv   (ilv),
        .addr  (col_addr)
    );

    assign cfg_len_log    = cfg.len_log;
    assign cfg_interleave = cfg.interleave;
    assign cfg_rd_lat     = cfg.rd_lat;
    assign cfg_single_wr  = cfg.single_wr;

endmodule

// File: rtl/bcg_checker.sv
// Checker for the burst column generator, bound to the top level.
// Watches only the top-level ports and checks the cycle-level rules.
module bcg_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [COL_W-1:0] cmd_col,
    input logic             term,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             col_last,
    input logic             mode_err,
    input logic [3:0]       cfg_len_log,
    input logic             cfg_interleave,
    input logic [1:0]       cfg_rd_lat,
    input logic             cfg_single_wr
);

    p_start_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

    p_after_last_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_valid) |=> !col_valid);

    p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    p_term_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !cmd_valid) |=> !col_valid);

    p_reject_keeps_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_err) |-> $stable({cfg_len_log, cfg_interleave, cfg_rd_lat, cfg_single_wr}));

    p_latency_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_lat == 2'd2) || (cfg_rd_lat == 2'd3));

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_col        (cmd_col),
    .term           (term),
    .col_valid      (col_valid),
    .col_addr       (col_addr),
    .col_last       (col_last),
    .mode_err       (mode_err),
    .cfg_len_log    (cfg_len_log),
    .cfg_interleave (cfg_interleave),
    .cfg_rd_lat     (cfg_rd_lat),
    .cfg_single_wr  (cfg_single_wr)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [11:0] mode_word = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_is_write = 1'b0;
    logic [8:0]  cmd_col = '0;
    logic        term = 1'b0;
    logic        col_valid;
    logic [8:0]  col_addr;
    logic        col_last;
    logic        mode_err;
    logic [3:0]  cfg_len_log;
    logic        cfg_interleave;
    logic [1:0]  cfg_rd_lat;
    logic        cfg_single_wr;

    int n_chk = 0;
    int n_bad = 0;

    // Expected settings tracked by the bench
    int e_ll  = 0;
    int e_ilv = 0;
    int e_lat = 2;
    int e_sw  = 0;
    int e_err = 0;

    always #2 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write), .cmd_col(cmd_col),
        .term(term), .col_valid(col_valid), .col_addr(col_addr),
        .col_last(col_last), .mode_err(mode_err), .cfg_len_log(cfg_len_log),
        .cfg_interleave(cfg_interleave), .cfg_rd_lat(cfg_rd_lat),
        .cfg_single_wr(cfg_single_wr)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input int bl, input int ilv, input int lat, input int wm);
        return {2'b00, 1'(wm), 2'b00, 3'(lat), 1'(ilv), 3'(bl)};
    endfunction

    // Expected column for beat k, following R5, R6 and R8.
    function automatic int exp_addr(input int start, input int ll, input int ilv, input int k);
        int msk = (1 << ll) - 1;
        if (ilv != 0) return start ^ (k & msk);
        return (start & ~msk & 511) | ((start + k) & msk);
    endfunction

    function automatic int eff_ll(input int wr);
        return (e_sw != 0 && wr != 0) ? 0 : e_ll;
    endfunction

    // Update the expected settings from a loaded word (R2, R3).
    task automatic expect_load(input logic [11:0] w);
        int bad = 0;
        int ll = 0;
        int lat = 0;
        case (w[2:0])
            3'b000: ll = 0;
            3'b001: ll = 1;
            3'b010: ll = 2;
            3'b011: ll = 3;
            3'b111: begin ll = 9; if (w[3]) bad = 1; end
            default: bad = 1;
        endcase
        if (w[6:4] == 3'b010) lat = 2;
        else if (w[6:4] == 3'b011) lat = 3;
        else bad = 1;
        if (bad != 0) e_err = 1;
        else begin
            e_err = 0; e_ll = ll; e_ilv = int'(w[3]); e_lat = lat; e_sw = int'(w[9]);
        end
    endtask

    task automatic load_mode(input logic [11:0] w);
        mode_load = 1'b1; mode_word = w;
        tick();
        mode_load = 1'b0;
        expect_load(w);
        chk("R3 mode_err", int'(mode_err), e_err);
        chk("R2/R3 len_log", int'(cfg_len_log), e_ll);
        chk("R2/R3 interleave", int'(cfg_interleave), e_ilv);
        chk("R2/R3 rd_lat", int'(cfg_rd_lat), e_lat);
        chk("R2/R3 single_wr", int'(cfg_single_wr), e_sw);
    endtask

    task automatic issue(input int col, input int wr);
        cmd_valid = 1'b1; cmd_col = 9'(col); cmd_is_write = 1'(wr);
    endtask

    // Step through n beats of a burst and compare each one (R4-R8).
    task automatic follow(input int start, input int ll, input int ilv, input int n);
        int len = 1 << ll;
        for (int k = 0; k < n; k++) begin
            tick();
            cmd_valid = 1'b0; term = 1'b0;
            chk("R4 col_valid", int'(col_valid), 1);
            chk(ilv != 0 ? "R6 col_addr" : (ll == 9 ? "R8 col_addr" : "R5 col_addr"),
                int'(col_addr), exp_addr(start, ll, ilv, k));
            chk(ll == 9 ? "R8 col_last" : "R7 col_last", int'(col_last),
                (ll != 9 && k == len - 1) ? 1 : 0);
        end
    endtask

    task automatic full_burst(input int start, input int wr);
        int ll = eff_ll(wr);
        int il = e_ilv;
        issue(start, wr);
        follow(start, ll, il, 1 << ll);
        tick();
        chk("R7 idle after last", int'(col_valid), 0);
    endtask

    initial begin
        int unsigned r;
        r = $urandom(32'd1234);
        repeat (3) tick();
        chk("R1 col_valid", int'(col_valid), 0);
        chk("R1 mode_err", int'(mode_err), 0);
        chk("R1 len_log", int'(cfg_len_log), 0);
        chk("R1 interleave", int'(cfg_interleave), 0);
        chk("R1 rd_lat", int'(cfg_rd_lat), 2);
        chk("R1 single_wr", int'(cfg_single_wr), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after reset", int'(col_valid), 0);

        // R1: default length of one beat
        full_burst(37, 0);

        // R5: sequential length 8 wraps inside the aligned block
        load_mode(mk(3, 0, 2, 0));
        full_burst(9'h0D, 0);
        // R6: interleaved length 4
        load_mode(mk(2, 1, 3, 0));
        full_burst(9'h07, 1);
        // R2: ignored bits set
        load_mode(mk(1, 0, 3, 0) | 12'hD80);
        full_burst(9'h1FF, 0);

        // R3: reserved codes keep the settings
        load_mode(mk(5, 0, 2, 0));
        load_mode(mk(7, 1, 2, 0));
        load_mode(mk(3, 0, 1, 0));
        full_burst(100, 1);
        load_mode(mk(3, 0, 2, 0));

        // R8: full page wraps 511 -> 0, then terminate
        load_mode(mk(7, 0, 2, 0));
        issue(500, 0);
        follow(500, 9, 0, 520);
        term = 1'b1;
        tick();
        term = 1'b0;
        chk("R9 terminate full page", int'(col_valid), 0);

        // R9: terminate in mid-burst and when idle
        load_mode(mk(3, 0, 2, 0));
        issue(40, 0);
        follow(40, 3, 0, 2);
        term = 1'b1;
        tick();
        chk("R9 terminate mid-burst", int'(col_valid), 0);
        tick();
        term = 1'b0;
        chk("R9 terminate while idle", int'(col_valid), 0);
        full_burst(41, 0);

        // R10: replace in mid-burst, and command together with terminate
        issue(64, 0);
        follow(64, 3, 0, 3);
        issue(130, 1);
        follow(130, 3, 0, 4);
        issue(203, 0);
        term = 1'b1;
        follow(203, 3, 0, 8);
        tick();
        chk("R10 idle after replacement", int'(col_valid), 0);

        // R11: single-beat writes
        load_mode(mk(2, 0, 2, 1));
        full_burst(22, 1);
        full_burst(22, 0);
        load_mode(mk(2, 0, 2, 0));
        full_burst(22, 1);

        // R12: command in the same cycle as a load uses the old settings
        load_mode(mk(1, 0, 2, 0));
        issue(50, 0);
        mode_load = 1'b1; mode_word = mk(3, 1, 2, 0);
        tick();
        mode_load = 1'b0; cmd_valid = 1'b0;
        chk("R12 first beat old setting", int'(col_addr), 50);
        chk("R12 old length not last", int'(col_last), 0);
        tick();
        chk("R12 old length second", int'(col_addr), 51);
        chk("R12 old length last", int'(col_last), 1);
        expect_load(mk(3, 1, 2, 0));
        tick();
        chk("R12 burst ended", int'(col_valid), 0);
        full_burst(50, 0);

        // Random mix of mode words and bursts
        for (int it = 0; it < 40; it++) begin
            int bl;
            int lat;
            int st;
            int wr;
            int pick = int'($urandom % 6);
            bl = (pick == 4) ? 7 : (pick == 5 ? int'($urandom % 8) : pick);
            lat = ($urandom % 5 == 0) ? int'($urandom % 8) : 2 + int'($urandom % 2);
            load_mode(mk(bl, int'($urandom % 2), lat, int'($urandom % 2))
                      | (12'($urandom) & 12'hD80));
            st = int'($urandom % 512);
            wr = int'($urandom % 2);
            if (eff_ll(wr) == 9) begin
                issue(st, wr);
                follow(st, 9, 0, 20);
                term = 1'b1;
                tick();
                term = 1'b0;
                chk("R9 random terminate", int'(col_valid), 0);
            end else begin
                full_burst(st, wr);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule